// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

A small shared word memory serves several requesters. Each one can load, store, load-linked (LL) or store-conditional (SC). An LL returns a word and leaves a reservation for that requester on that address. A later SC from the same requester writes only if nothing has broken that reservation in the meantime, and it reports whether the write happened. Memory is never locked and no requester is ever stalled. The block only detects whether an LL/SC pair could have looked atomic, and it refuses the store when the pair could not.

A reservation is broken by a write to its address from another requester, by a successful SC from another requester, or by an eviction pulse on that address. Software that gets a failed SC loops back to its LL. All requests that arrive in a cycle are served in that cycle, in fixed priority order. Lower indices come first, and each request sees the memory and the reservations left by the requests ahead of it.

Top module: `llsc_monitor`

## Requirements
- R1: An LL (op code 2) returns the addressed word and records a reservation for that requester on that address.
- R2: An SC (op code 3) whose requester holds a reservation on the same address writes its data and returns status 1. The response (resp_valid_o, data, status) appears on the cycle after the request, and no request is ever stalled.
- R3: An SC with no reservation, or with a reservation on a different address, returns status 0 and leaves memory unchanged.
- R4: Every SC clears its own requester's reservation, whether it succeeds or fails, so a second SC without a new LL fails.
- R5: Each requester holds at most one reservation. A new LL replaces the earlier one.
- R6: A plain store (op code 1) clears the reservations of other requesters on that address. It does not clear the storing requester's own reservation, and it does not touch reservations on other addresses.
- R7: A successful SC clears the reservations of other requesters on the same address.
- R8: An eviction pulse clears every reservation on its address before that cycle's requests are processed. Reservations on other addresses survive.
- R9: Requests in the same cycle are handled in index order, with index 0 first. A request sees the writes and reservation changes made by lower indices in that cycle, so of two SCs to one reserved address only the lower index succeeds.
- R10: A load (op code 0) returns the current word. Read data is the word as it stood just before the request's own write. Status is 0 for any op other than SC.
- R11: After reset the memory reads all zeros, no reservation exists, and resp_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_REQ | Request present, one bit per requester |
| req_op_i | input | 2*N_REQ | Op per requester: 0 load, 1 store, 2 LL, 3 SC |
| req_addr_i | input | ADDR_W*N_REQ | Word address per requester |
| req_wdata_i | input | DATA_W*N_REQ | Write data per requester |
| evict_valid_i | input | 1 | Eviction pulse |
| evict_addr_i | input | ADDR_W | Address hit by the eviction |
| resp_valid_o | output | N_REQ | Response valid, one cycle after request |
| resp_rdata_o | output | DATA_W*N_REQ | Read data per requester |
| resp_sc_ok_o | output | N_REQ | SC success (1) or failure (0) |

## Verification
Reservation state is not visible at the ports. A wrong reservation bit or address shows up only at the next SC from that requester, as a wrong status, and one cycle later as a wrong word on a following load. The bench therefore closes each scenario with SCs and loads, so that any corrupted reservation is exposed within two cycles. An exhaustive sweep of every op mix for three requesters on a single contended address checks the in-cycle priority chain. This catches a write that invalidates in the wrong order, or a reservation that is consumed in the wrong order, on the response cycle.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LL    = 2'd2,
    OP_SC    = 2'd3
  } llsc_op_e;
endpackage

// File: rtl/llsc_evict_stage.sv
module llsc_evict_stage #(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 4
) (
  input  logic [N_REQ-1:0]        rv_i,
  input  logic [N_REQ*ADDR_W-1:0] ra_i,
  input  logic                    evict_valid_i,
  input  logic [ADDR_W-1:0]       evict_addr_i,
  output logic [N_REQ-1:0]        rv_o
);
  for (genvar j = 0; j < N_REQ; j++) begin : g_slot
    assign rv_o[j] = rv_i[j] &&
                     !(evict_valid_i && (ra_i[j*ADDR_W +: ADDR_W] == evict_addr_i));
  end
endmodule

// File: rtl/llsc_req_stage.sv
module llsc_req_stage
  import llsc_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int IDX    = 0,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int MEM_W = DEPTH * DATA_W
) (
  input  logic                    valid_i,
  input  logic [1:0]              op_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [MEM_W-1:0]        mem_i,
  input  logic [N_REQ-1:0]        rv_i,
  input  logic [N_REQ*ADDR_W-1:0] ra_i,
  output logic [MEM_W-1:0]        mem_o,
  output logic [N_REQ-1:0]        rv_o,
  output logic [N_REQ*ADDR_W-1:0] ra_o,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    sc_ok_o
);
  logic own;
  logic wr;

  assign own = rv_i[IDX] && (ra_i[IDX*ADDR_W +: ADDR_W] == addr_i);

  always_comb begin
    mem_o   = mem_i;
    rv_o    = rv_i;
    ra_o    = ra_i;
    sc_ok_o = 1'b0;
    wr      = 1'b0;
    rdata_o = '0;
    if (valid_i) begin
      rdata_o = mem_i[addr_i*DATA_W +: DATA_W];
      case (llsc_op_e'(op_i))
        OP_STORE: wr = 1'b1;
        OP_LL: begin
          rv_o[IDX] = 1'b1;
          ra_o[IDX*ADDR_W +: ADDR_W] = addr_i;
        end
        OP_SC: begin
          rv_o[IDX] = 1'b0;
          sc_ok_o   = own;
          wr        = own;
        end
        default: ;
      endcase
    end
    if (wr) begin
      mem_o[addr_i*DATA_W +: DATA_W] = wdata_i;
      for (int j = 0; j < N_REQ; j++) begin
        if (j != IDX && ra_i[j*ADDR_W +: ADDR_W] == addr_i) rv_o[j] = 1'b0;
      end
    end
  end

  // R3
  sc_fail_no_write_chk: assert final (!(valid_i && op_i == 2'd3 && !sc_ok_o) || mem_o == mem_i);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int MEM_W = DEPTH * DATA_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_REQ-1:0]        req_valid_i,
  input  logic [2*N_REQ-1:0]      req_op_i,
  input  logic [N_REQ*ADDR_W-1:0] req_addr_i,
  input  logic [N_REQ*DATA_W-1:0] req_wdata_i,
  input  logic                    evict_valid_i,
  input  logic [ADDR_W-1:0]       evict_addr_i,
  output logic [N_REQ-1:0]        resp_valid_o,
  output logic [N_REQ*DATA_W-1:0] resp_rdata_o,
  output logic [N_REQ-1:0]        resp_sc_ok_o
);
  logic [MEM_W-1:0]        mem_q;
  logic [N_REQ-1:0]        rv_q;
  logic [N_REQ*ADDR_W-1:0] ra_q;

  logic [MEM_W-1:0]        mem_c [N_REQ+1];
  logic [N_REQ-1:0]        rv_c  [N_REQ+1];
  logic [N_REQ*ADDR_W-1:0] ra_c  [N_REQ+1];
  logic [N_REQ*DATA_W-1:0] rdata_d;
  logic [N_REQ-1:0]        sc_ok_d;

  assign mem_c[0] = mem_q;
  assign ra_c[0]  = ra_q;

  llsc_evict_stage #(.N_REQ(N_REQ), .ADDR_W(ADDR_W)) evict_i (
    .rv_i          (rv_q),
    .ra_i          (ra_q),
    .evict_valid_i (evict_valid_i),
    .evict_addr_i  (evict_addr_i),
    .rv_o          (rv_c[0])
  );

  // Priority chain: stage i sees the effects of stages 0..i-1
  for (genvar i = 0; i < N_REQ; i++) begin : g_req
    llsc_req_stage #(.N_REQ(N_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX(i)) stage_i (
      .valid_i (req_valid_i[i]),
      .op_i    (req_op_i[2*i +: 2]),
      .addr_i  (req_addr_i[i*ADDR_W +: ADDR_W]),
      .wdata_i (req_wdata_i[i*DATA_W +: DATA_W]),
      .mem_i   (mem_c[i]),
      .rv_i    (rv_c[i]),
      .ra_i    (ra_c[i]),
      .mem_o   (mem_c[i+1]),
      .rv_o    (rv_c[i+1]),
      .ra_o    (ra_c[i+1]),
      .rdata_o (rdata_d[i*DATA_W +: DATA_W]),
      .sc_ok_o (sc_ok_d[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q        <= '0;
      rv_q         <= '0;
      ra_q         <= '0;
      resp_valid_o <= '0;
      resp_rdata_o <= '0;
      resp_sc_ok_o <= '0;
    end else begin
      mem_q        <= mem_c[N_REQ];
      rv_q         <= rv_c[N_REQ];
      ra_q         <= ra_c[N_REQ];
      resp_valid_o <= req_valid_i;
      resp_rdata_o <= rdata_d;
      resp_sc_ok_o <= sc_ok_d;
    end
  end

  logic any_wr;
  always_comb begin
    any_wr = 1'b0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req_valid_i[i] && (req_op_i[2*i +: 2] == 2'd1 || req_op_i[2*i +: 2] == 2'd3))
        any_wr = 1'b1;
    end
  end

  // R3
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(any_wr) |-> $stable(mem_q));

  for (genvar i = 0; i < N_REQ; i++) begin : g_chk
    // R10
    ok_only_sc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resp_sc_ok_o[i] |-> resp_valid_o[i] && $past(req_op_i[2*i +: 2] == 2'd3));
    // R4
    sc_consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(req_valid_i[i] && req_op_i[2*i +: 2] == 2'd3) |-> !rv_q[i]);
    // R8
    evict_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(evict_valid_i) && rv_q[i] && ra_q[i*ADDR_W +: ADDR_W] == $past(evict_addr_i))
      |-> $past(req_valid_i[i] && req_op_i[2*i +: 2] == 2'd2 &&
                req_addr_i[i*ADDR_W +: ADDR_W] == evict_addr_i));
    if (i == N_REQ - 1) begin : g_last
      // R1
      ll_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(req_valid_i[i] && req_op_i[2*i +: 2] == 2'd2)
        |-> rv_q[i] && ra_q[i*ADDR_W +: ADDR_W] == $past(req_addr_i[i*ADDR_W +: ADDR_W]));
    end
  end
endmodule

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb_top;
  localparam int NR = 3;
  localparam int AW = 2;
  localparam int DW = 8;
  localparam int DP = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NR-1:0]    req_valid;
  logic [2*NR-1:0]  req_op;
  logic [NR*AW-1:0] req_addr;
  logic [NR*DW-1:0] req_wdata;
  logic             ev_v;
  logic [AW-1:0]    ev_a;
  logic [NR-1:0]    resp_valid;
  logic [NR*DW-1:0] resp_rdata;
  logic [NR-1:0]    resp_ok;

  always #10 clk = ~clk;

  llsc_monitor #(.N_REQ(NR), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .evict_valid_i(ev_v), .evict_addr_i(ev_a),
    .resp_valid_o(resp_valid), .resp_rdata_o(resp_rdata), .resp_sc_ok_o(resp_ok)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // stimulus slots
  bit         b_v [NR];
  logic [1:0] b_op[NR];
  logic [AW-1:0] b_a[NR];
  logic [DW-1:0] b_d[NR];

  // requirement-level model state
  logic [DW-1:0] m_mem[DP];
  bit            m_rv[NR];
  logic [AW-1:0] m_ra[NR];
  bit            e_v[NR];
  logic [DW-1:0] e_rd[NR];
  bit            e_ok[NR];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic req(int i, int op, int a, int d);
    b_v[i] = 1; b_op[i] = op[1:0]; b_a[i] = a[AW-1:0]; b_d[i] = d[DW-1:0];
  endtask

  task automatic model();
    if (ev_v)
      for (int j = 0; j < NR; j++) if (m_ra[j] == ev_a) m_rv[j] = 0;
    for (int i = 0; i < NR; i++) begin
      bit w = 0;
      e_v[i] = b_v[i]; e_ok[i] = 0; e_rd[i] = '0;
      if (b_v[i]) begin
        e_rd[i] = m_mem[b_a[i]];
        case (b_op[i])
          2'd1: w = 1;
          2'd2: begin m_rv[i] = 1; m_ra[i] = b_a[i]; end
          2'd3: begin
            e_ok[i] = m_rv[i] && (m_ra[i] == b_a[i]);
            w = e_ok[i]; m_rv[i] = 0;
          end
          default: ;
        endcase
        if (w) begin
          m_mem[b_a[i]] = b_d[i];
          for (int j = 0; j < NR; j++) if (j != i && m_ra[j] == b_a[i]) m_rv[j] = 0;
        end
      end
    end
  endtask

  task automatic step(string tag);
    for (int i = 0; i < NR; i++) begin
      req_valid[i] = b_v[i];
      req_op[2*i +: 2] = b_op[i];
      req_addr[i*AW +: AW] = b_a[i];
      req_wdata[i*DW +: DW] = b_d[i];
    end
    model();
    @(negedge clk);
    for (int i = 0; i < NR; i++) begin
      chk(tag, {31'd0, resp_valid[i]}, {31'd0, e_v[i]});
      if (e_v[i]) begin
        chk(tag, {24'd0, resp_rdata[i*DW +: DW]}, {24'd0, e_rd[i]});
        chk(tag, {31'd0, resp_ok[i]}, {31'd0, e_ok[i]});
      end
    end
    for (int i = 0; i < NR; i++) begin b_v[i] = 0; b_op[i] = 0; b_a[i] = 0; b_d[i] = 0; end
    ev_v = 0; ev_a = 0;
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0; ev_v = 0; ev_a = '0;
    for (int i = 0; i < NR; i++) begin b_v[i] = 0; b_op[i] = 0; b_a[i] = 0; b_d[i] = 0; m_rv[i] = 0; m_ra[i] = 0; end
    for (int a = 0; a < DP; a++) m_mem[a] = '0;
    repeat (3) @(negedge clk);
    chk("R11", {29'd0, resp_valid}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 memory cleared
    for (int a = 0; a < DP; a++) begin req(0, 0, a, 0); step("R11"); end
    // R11 no reservation after reset
    req(1, 3, 0, 8'h77); step("R11");

    // R1 / R2
    req(0, 1, 1, 8'h5a); step("R10");
    req(1, 2, 1, 0); step("R1");
    req(1, 3, 1, 8'h11); step("R2");
    req(2, 0, 1, 0); step("R2");
    // R3
    req(2, 3, 2, 8'h33); step("R3");
    req(2, 0, 2, 0); step("R3");
    req(2, 2, 3, 0); step("R3");
    req(2, 3, 2, 8'h44); step("R3");
    req(2, 0, 2, 0); step("R3");
    // R4
    req(0, 2, 0, 0); step("R4");
    req(0, 3, 0, 8'h21); step("R4");
    req(0, 3, 0, 8'h22); step("R4");
    req(0, 0, 0, 0); step("R4");
    // R5
    req(1, 2, 1, 0); step("R5");
    req(1, 2, 2, 0); step("R5");
    req(1, 3, 1, 8'h91); step("R5");
    req(1, 2, 1, 0); step("R5");
    req(1, 2, 2, 0); step("R5");
    req(1, 3, 2, 8'h92); step("R5");
    // R6
    req(0, 2, 3, 0); step("R6");
    req(1, 1, 3, 8'h66); step("R6");
    req(0, 3, 3, 8'h67); step("R6");
    req(0, 2, 3, 0); step("R6");
    req(1, 1, 2, 8'h68); step("R6");
    req(0, 3, 3, 8'h69); step("R6");
    req(0, 2, 3, 0); step("R6");
    req(0, 1, 3, 8'h6a); step("R6");
    req(0, 3, 3, 8'h6b); step("R6");
    req(2, 0, 3, 0); step("R6");
    // R7
    req(0, 2, 1, 0); req(1, 2, 1, 0); step("R7");
    req(0, 3, 1, 8'h71); step("R7");
    req(1, 3, 1, 8'h72); step("R7");
    // R8
    req(2, 2, 0, 0); step("R8");
    ev_v = 1; ev_a = 0; step("R8");
    req(2, 3, 0, 8'h81); step("R8");
    req(2, 2, 0, 0); step("R8");
    ev_v = 1; ev_a = 1; step("R8");
    req(2, 3, 0, 8'h82); step("R8");
    req(2, 2, 0, 0); step("R8");
    ev_v = 1; ev_a = 0; req(2, 3, 0, 8'h83); step("R8");
    ev_v = 1; ev_a = 0; req(2, 2, 0, 0); step("R8");
    req(2, 3, 0, 8'h84); step("R8");

    // R9 exhaustive op mix on one contended address
    for (int c = 0; c < 64; c++) begin
      for (int i = 0; i < NR; i++) req(i, 2, 1, 0);
      step("R9");
      for (int i = 0; i < NR; i++) req(i, (c >> (2*i)) & 3, 1, c*4 + i);
      step("R9");
      for (int i = 0; i < NR; i++) req(i, 3, 1, 8'hc0 + i);
      step("R9");
      req(0, 0, 1, 0); step("R9");
    end

    // R10 random traffic, small address space
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < NR; i++)
        if (($urandom % 4) != 0) req(i, $urandom % 4, $urandom % DP, $urandom % 256);
      if (($urandom % 8) == 0) begin ev_v = 1; ev_a = AW'($urandom % DP); end
      step("R10");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule